// File: doc/BRIEF.md
# Push-Button Step and Auto-Repeat Sequencer

This block turns two mechanical push buttons into clean step commands for a digitally adjusted setting such as a volume or brightness level. Each button input is low while pressed and rests high. After synchronisation and debouncing, a single press yields one increment or decrement strobe. A button kept down keeps stepping, first at a relaxed pace and then, after a longer hold, at a quicker pace.

The two buttons together form a gesture. If both go down close together and stay down long enough, the block asks the surrounding logic to power down the adjusted element. If the second button arrives too late, the block treats the input as a fumble and ignores everything until both buttons are up again. While the powered-down condition is in effect, the next qualified press asks for a wake-up instead of a step.

All timing comes from a one-cycle millisecond tick enable, and every duration is a parameter counted in ticks. The outputs are one-cycle strobes in the clock domain, each issued in the cycle after a tick.

Top module: `pb_stepper`

## Requirements
- R1: A button low for fewer ticks than DEB_TICKS (default 15) produces no strobe at all.
- R2: A button low for more than DEB_TICKS but released before the pairing window of PAIR_TICKS (default 15) ticks has run out produces exactly one strobe: step_inc for the up button, step_dec for the down button.
- R3: While one button stays held, a further step follows every SLOW_TICKS (default 250) ticks: holds of 200 ms and 600 ms give 1 and 3 steps.
- R4: After one button has been held for FAST_AFTER (default 1000) ticks, the step interval shrinks to FAST_TICKS (default 50): a 1500 ms hold gives 14 steps.
- R5: Releasing the button ends the repeat; the next press starts again at the slow pace (a 600 ms hold right after a 1500 ms hold gives 3 steps).
- R6: If the second button is debounced more than PAIR_TICKS after the first, no further command is issued and every input is ignored until both buttons are released; a later press works normally.
- R7: Both buttons debounced within PAIR_TICKS of each other and held for SD_TICKS (default 2000) produce exactly one sd_enter strobe and no step strobe.
- R8: A valid two-button press released before SD_TICKS produces no strobe of any kind.
- R9: After sd_enter, the next qualified single press produces one sd_exit strobe instead of its first step; presses after that step normally again.
- R10: Every strobe lasts one clock cycle and at most one of the four strobes is high in any cycle.
- R11: While rst is high and in the cycle after, all four strobes are low.
- R12: A strobe is only ever high in the cycle that follows a cycle with tick_1ms high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1ms | input | 1 | One-cycle timing enable, once per millisecond |
| btn_up_n | input | 1 | Up button, low while pressed, asynchronous |
| btn_dn_n | input | 1 | Down button, low while pressed, asynchronous |
| step_inc | output | 1 | One-cycle increment command |
| step_dec | output | 1 | One-cycle decrement command |
| sd_enter | output | 1 | One-cycle request to enter the powered-down condition |
| sd_exit | output | 1 | One-cycle request to leave the powered-down condition |

## Verification
The bench targets the hold-length boundaries: a 10 ms glitch that a debouncer counting the wrong way would turn into a step, a 1500 ms hold whose step count reveals a repeat interval that never speeds up or speeds up at the wrong moment, and a follow-up hold that catches a speed flag left set from the previous press. It drives both gestures, the close pair that must end in a single power-down request with no stray step, and the late pair that must freeze the block until the last button lifts, so a design that forgot the lockout keeps stepping while one button remains. After power-down it checks that the first press wakes the block instead of stepping, which a design that never clears its power-down state would repeat forever.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_SINGLE,
        ST_PAIR,
        ST_LOCK
    } seq_state_e;

    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } dir_e;

    typedef struct packed {
        logic inc;
        logic dec;
        logic sd_enter;
        logic sd_exit;
    } cmd_t;

    localparam cmd_t CMD_NONE = '0;

    function automatic cmd_t step_cmd(input dir_e d);
        cmd_t c;
        c = CMD_NONE;
        if (d == DIR_UP) c.inc = 1'b1;
        else             c.dec = 1'b1;
        return c;
    endfunction

    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pbs_sync.sv
module pbs_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage0;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage0 <= '1;
            q      <= '1;
        end else begin
            stage0 <= d;
            q      <= stage0;
        end
    end
endmodule

// File: rtl/pbs_debounce.sv
module pbs_debounce
    import pbs_pkg::*;
#(
    parameter int DEB_TICKS = 15,
    parameter int GAP_TICKS = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pressed_raw,
    output logic held
);
    localparam int CW = cnt_width(max2(DEB_TICKS, GAP_TICKS));

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= 1'b0;
            cnt  <= '0;
        end else if (tick) begin
            if (held) begin
                if (pressed_raw) begin
                    cnt <= '0;
                end else if (cnt == CW'(GAP_TICKS - 1)) begin
                    held <= 1'b0;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                if (!pressed_raw) begin
                    cnt <= '0;
                end else if (cnt == CW'(DEB_TICKS - 1)) begin
                    held <= 1'b1;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pbs_ctrl.sv
module pbs_ctrl
    import pbs_pkg::*;
#(
    parameter int PAIR_TICKS = 15,
    parameter int SLOW_TICKS = 250,
    parameter int FAST_TICKS = 50,
    parameter int FAST_AFTER = 1000,
    parameter int SD_TICKS   = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic up_held,
    input  logic dn_held,
    output cmd_t cmd
);
    localparam int WW = cnt_width(PAIR_TICKS);
    localparam int RW = cnt_width(max2(SLOW_TICKS, FAST_TICKS));
    localparam int HW = cnt_width(FAST_AFTER);
    localparam int PW = cnt_width(SD_TICKS);

    seq_state_e    state_q, state_d;
    dir_e          dir_q, dir_d;
    logic          sd_q, sd_d;
    logic [WW-1:0] win_q, win_d;
    logic [RW-1:0] rep_q, rep_d;
    logic [HW-1:0] hold_q, hold_d;
    logic [PW-1:0] pair_q, pair_d;
    cmd_t          cmd_d;

    logic          own_held, other_held;
    logic [RW-1:0] rep_limit;

    always_comb begin
        own_held   = (dir_q == DIR_UP) ? up_held : dn_held;
        other_held = (dir_q == DIR_UP) ? dn_held : up_held;
        rep_limit  = (hold_q >= HW'(FAST_AFTER)) ? RW'(FAST_TICKS - 1)
                                                 : RW'(SLOW_TICKS - 1);
    end

    always_comb begin
        state_d = state_q;
        dir_d   = dir_q;
        sd_d    = sd_q;
        win_d   = win_q;
        rep_d   = rep_q;
        hold_d  = hold_q;
        pair_d  = pair_q;
        cmd_d   = CMD_NONE;

        if (tick) begin
            if ((state_q == ST_ARM || state_q == ST_SINGLE) &&
                hold_q != HW'(FAST_AFTER)) begin
                hold_d = hold_q + 1'b1;
            end

            case (state_q)
                ST_IDLE: begin
                    if (up_held && dn_held) begin
                        state_d = ST_PAIR;
                        pair_d  = '0;
                    end else if (up_held || dn_held) begin
                        state_d = ST_ARM;
                        dir_d   = up_held ? DIR_UP : DIR_DN;
                        win_d   = '0;
                        hold_d  = '0;
                    end
                end

                ST_ARM: begin
                    if (other_held) begin
                        state_d = ST_PAIR;
                        pair_d  = '0;
                    end else if (!own_held || win_q == WW'(PAIR_TICKS - 1)) begin
                        if (sd_q) begin
                            cmd_d.sd_exit = 1'b1;
                            sd_d          = 1'b0;
                        end else begin
                            cmd_d = step_cmd(dir_q);
                        end
                        state_d = own_held ? ST_SINGLE : ST_IDLE;
                        rep_d   = '0;
                    end else begin
                        win_d = win_q + 1'b1;
                    end
                end

                ST_SINGLE: begin
                    if (other_held) begin
                        state_d = ST_LOCK;
                    end else if (!own_held) begin
                        state_d = ST_IDLE;
                    end else if (rep_q >= rep_limit) begin
                        cmd_d = step_cmd(dir_q);
                        rep_d = '0;
                    end else begin
                        rep_d = rep_q + 1'b1;
                    end
                end

                ST_PAIR: begin
                    if (!(up_held && dn_held)) begin
                        state_d = ST_LOCK;
                    end else if (pair_q == PW'(SD_TICKS - 1)) begin
                        cmd_d.sd_enter = 1'b1;
                        sd_d           = 1'b1;
                        state_d        = ST_LOCK;
                    end else begin
                        pair_d = pair_q + 1'b1;
                    end
                end

                ST_LOCK: begin
                    if (!up_held && !dn_held) state_d = ST_IDLE;
                end

                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            dir_q   <= DIR_UP;
            sd_q    <= 1'b0;
            win_q   <= '0;
            rep_q   <= '0;
            hold_q  <= '0;
            pair_q  <= '0;
            cmd     <= CMD_NONE;
        end else begin
            state_q <= state_d;
            dir_q   <= dir_d;
            sd_q    <= sd_d;
            win_q   <= win_d;
            rep_q   <= rep_d;
            hold_q  <= hold_d;
            pair_q  <= pair_d;
            cmd     <= cmd_d;
        end
    end
endmodule

// File: rtl/pb_stepper.sv
module pb_stepper
    import pbs_pkg::*;
#(
    parameter int DEB_TICKS  = 15,
    parameter int GAP_TICKS  = 1,
    parameter int PAIR_TICKS = 15,
    parameter int SLOW_TICKS = 250,
    parameter int FAST_TICKS = 50,
    parameter int FAST_AFTER = 1000,
    parameter int SD_TICKS   = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_1ms,
    input  logic btn_up_n,
    input  logic btn_dn_n,
    output logic step_inc,
    output logic step_dec,
    output logic sd_enter,
    output logic sd_exit
);
    localparam int NBTN = 2;

    logic [NBTN-1:0] btn_sync_n;
    logic [NBTN-1:0] btn_held;
    cmd_t            cmd;

    pbs_sync #(.WIDTH(NBTN)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({btn_dn_n, btn_up_n}),
        .q   (btn_sync_n)
    );

    for (genvar b = 0; b < NBTN; b++) begin : g_deb
        pbs_debounce #(
            .DEB_TICKS (DEB_TICKS),
            .GAP_TICKS (GAP_TICKS)
        ) i_deb (
            .clk         (clk),
            .rst         (rst),
            .tick        (tick_1ms),
            .pressed_raw (~btn_sync_n[b]),
            .held        (btn_held[b])
        );
    end

    pbs_ctrl #(
        .PAIR_TICKS (PAIR_TICKS),
        .SLOW_TICKS (SLOW_TICKS),
        .FAST_TICKS (FAST_TICKS),
        .FAST_AFTER (FAST_AFTER),
        .SD_TICKS   (SD_TICKS)
    ) i_ctrl (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_1ms),
        .up_held (btn_held[0]),
        .dn_held (btn_held[1]),
        .cmd     (cmd)
    );

    assign step_inc = cmd.inc;
    assign step_dec = cmd.dec;
    assign sd_enter = cmd.sd_enter;
    assign sd_exit  = cmd.sd_exit;
endmodule

// File: rtl/pb_stepper_chk.sv
module pb_stepper_chk (
    input logic clk,
    input logic rst,
    input logic tick_1ms,
    input logic step_inc,
    input logic step_dec,
    input logic sd_enter,
    input logic sd_exit
);
    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({step_inc, step_dec, sd_enter, sd_exit}));

    assert_inc_single_R10: assert property (@(posedge clk) disable iff (rst)
        step_inc |=> !step_inc);

    assert_dec_single_R10: assert property (@(posedge clk) disable iff (rst)
        step_dec |=> !step_dec);

    assert_exit_single_R9: assert property (@(posedge clk) disable iff (rst)
        sd_exit |=> !sd_exit);

    assert_tick_aligned_R12: assert property (@(posedge clk) disable iff (rst)
        (step_inc || step_dec || sd_enter || sd_exit) |-> $past(tick_1ms));
endmodule

bind pb_stepper pb_stepper_chk i_chk (.*);

// File: tb/test_pb_stepper.sv
`timescale 1ns/1ps
module test_pb_stepper;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_1ms = 1'b0;
    logic btn_up_n = 1'b1;
    logic btn_dn_n = 1'b1;
    logic step_inc, step_dec, sd_enter, sd_exit;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int n_inc = 0, n_dec = 0, n_sde = 0, n_sdx = 0;
    int n_wide = 0, n_multi = 0, n_misalign = 0;

    always #2 clk = ~clk;

    pb_stepper i_pb_stepper (
        .clk      (clk),
        .rst      (rst),
        .tick_1ms (tick_1ms),
        .btn_up_n (btn_up_n),
        .btn_dn_n (btn_dn_n),
        .step_inc (step_inc),
        .step_dec (step_dec),
        .sd_enter (sd_enter),
        .sd_exit  (sd_exit)
    );

    // tick generator and output monitor in one loop, sampled at negedge
    initial begin
        int phase = 0;
        logic p_inc = 1'b0, p_dec = 1'b0, p_sde = 1'b0, p_sdx = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (step_inc) n_inc++;
                if (step_dec) n_dec++;
                if (sd_enter) n_sde++;
                if (sd_exit)  n_sdx++;
                if ((step_inc && p_inc) || (step_dec && p_dec) ||
                    (sd_enter && p_sde) || (sd_exit && p_sdx)) n_wide++;
                if ((32'(step_inc) + 32'(step_dec) + 32'(sd_enter) + 32'(sd_exit)) > 1)
                    n_multi++;
                if ((step_inc || step_dec || sd_enter || sd_exit) && !tick_1ms)
                    n_misalign++;
            end
            p_inc = step_inc; p_dec = step_dec; p_sde = sd_enter; p_sdx = sd_exit;
            tick_1ms = (phase == 3);
            phase = (phase + 1) % 4;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ms(input int ms);
        repeat (ms * 4) @(negedge clk);
    endtask

    task automatic clear_counts();
        n_inc = 0; n_dec = 0; n_sde = 0; n_sdx = 0;
    endtask

    task automatic press(input bit up, input int ms);
        if (up) btn_up_n = 1'b0; else btn_dn_n = 1'b0;
        wait_ms(ms);
        btn_up_n = 1'b1; btn_dn_n = 1'b1;
        wait_ms(50);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (10) @(negedge clk);
        chk("R11 strobes in reset", 32'(step_inc) + 32'(step_dec) + 32'(sd_enter) + 32'(sd_exit), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 strobes after reset", 32'(step_inc) + 32'(step_dec) + 32'(sd_enter) + 32'(sd_exit), 0);
        wait_ms(5);
    endtask

    task automatic t_glitch();
        clear_counts();
        press(1'b1, 10);
        chk("R1 glitch inc", n_inc, 0);
        chk("R1 glitch dec", n_dec, 0);
    endtask

    task automatic t_tap();
        clear_counts();
        press(1'b1, 20);
        chk("R2 tap up inc", n_inc, 1);
        chk("R2 tap up dec", n_dec, 0);
        clear_counts();
        press(1'b0, 20);
        chk("R2 tap down dec", n_dec, 1);
        chk("R2 tap down inc", n_inc, 0);
    endtask

    task automatic t_slow();
        clear_counts();
        press(1'b1, 200);
        chk("R3 hold 200 inc", n_inc, 1);
        clear_counts();
        press(1'b1, 600);
        chk("R3 hold 600 inc", n_inc, 3);
    endtask

    task automatic t_fast();
        clear_counts();
        press(1'b0, 1500);
        chk("R4 hold 1500 dec", n_dec, 14);
        clear_counts();
        press(1'b0, 600);
        chk("R5 slow again dec", n_dec, 3);
    endtask

    task automatic t_stagger();
        clear_counts();
        btn_up_n = 1'b0;
        wait_ms(40);
        btn_dn_n = 1'b0;
        wait_ms(300);
        btn_dn_n = 1'b1;
        wait_ms(600);
        btn_up_n = 1'b1;
        wait_ms(50);
        chk("R6 late pair inc", n_inc, 1);
        chk("R6 late pair dec", n_dec, 0);
        chk("R6 late pair sd", n_sde, 0);
        clear_counts();
        press(1'b1, 20);
        chk("R6 after lock inc", n_inc, 1);
    endtask

    task automatic t_pair_short();
        clear_counts();
        btn_up_n = 1'b0;
        wait_ms(5);
        btn_dn_n = 1'b0;
        wait_ms(500);
        btn_up_n = 1'b1; btn_dn_n = 1'b1;
        wait_ms(50);
        chk("R8 short pair strobes", n_inc + n_dec + n_sde + n_sdx, 0);
    endtask

    task automatic t_pair_sd();
        clear_counts();
        btn_dn_n = 1'b0;
        wait_ms(5);
        btn_up_n = 1'b0;
        wait_ms(2100);
        btn_up_n = 1'b1; btn_dn_n = 1'b1;
        wait_ms(50);
        chk("R7 sd_enter count", n_sde, 1);
        chk("R7 steps in pair", n_inc + n_dec, 0);
    endtask

    task automatic t_exit();
        clear_counts();
        press(1'b1, 100);
        chk("R9 sd_exit count", n_sdx, 1);
        chk("R9 no step on exit", n_inc, 0);
        clear_counts();
        press(1'b1, 100);
        chk("R9 step after exit", n_inc, 1);
        chk("R9 no second exit", n_sdx, 0);
    endtask

    initial begin
        t_reset();
        t_glitch();
        t_tap();
        t_slow();
        t_fast();
        t_stagger();
        t_pair_short();
        t_pair_sd();
        t_exit();
        chk("R10 wide strobes", n_wide, 0);
        chk("R10 overlapping strobes", n_multi, 0);
        chk("R12 strobes off tick", n_misalign, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule